// File: doc/BRIEF.md
# Serial Controller Data and Interrupt Front-End

This block sits between a processor bus and the byte-level core of a serial controller that runs either as a UART or as an SPI master. A single data register serves both directions: a bus write queues a byte for the transmitter, and a bus read takes the oldest received byte. The serializer and the bit-rate generation are outside the block; a plain byte stream stands in for them. Transmit bytes leave through a valid/ready pair. Received bytes arrive as one-cycle strobes, each carrying a parity-error flag and a framing-error flag.

The received byte and its two error flags are stored together, so the error status always refers to the byte software will read next. An overrun flag records a byte lost to a full receive queue. Three interrupt conditions are provided: receive data waiting, transmit space free, and transmitter idle. Each can be made sticky on its rising edge or can follow its condition directly.

Register map (2-bit `addr`): 0 data, 1 status, 2 interrupt mode, 3 interrupt pending. Unused read bits return zero.

Top module: `sc_frontend`

## Requirements
- R1: A bus write to address 0 pushes `wdata[7:0]` into a 4-entry transmit FIFO. Bytes appear on `tx_data` in write order while `tx_valid` is high, and each is removed at a clock edge where `tx_valid` and `tx_ready` are both high.
- R2: A write to address 0 while the transmit FIFO holds 4 bytes is ignored.
- R3: A bus read at address 0 returns the oldest received byte in `rdata[7:0]` with bits 31:8 zero, and removes that byte at the clock edge. A read of an empty receive FIFO returns zero and changes nothing.
- R4: A byte that arrives on `rx_valid` while the receive FIFO is full, and no read frees a slot in that cycle, is dropped and sets the overrun flag (status bit 2).
- R5: A data read that removes a byte clears the overrun flag, unless a new overrun occurs in the same cycle.
- R6: With `uart_mode` high, status bit 0 (parity error) and status bit 1 (framing error) are loaded on each data read with the flags of the byte that heads the FIFO after the read. They are cleared when the FIFO is empty after the read. A byte that arrives into an empty FIFO loads its own flags. A byte that arrives in the same cycle as a read of the last stored byte counts as the new head.
- R7: With `uart_mode` low, status bits 0 and 1 hold their value across data reads and byte arrivals.
- R8: Interrupt mode register (address 2), reset value 0: bit 0 controls receive-data-available, bit 1 controls transmit-free, and bit 2 controls transmitter-idle. A bit value of 0 selects edge mode and 1 selects level mode. The status, pending and data registers also reset to zero.
- R9: In edge mode, a pending bit (address 3, same bit order as the mode register) is set one clock after the rising edge of its condition and stays set until a write of 1 to that bit at address 3. A set in the same cycle as the clear wins. Because the conditions register a rise out of reset, transmit-free and transmitter-idle become pending in the first cycle after reset.
- R10: In level mode, a pending bit equals its condition in the same cycle.
- R11: The receive-available condition is "receive FIFO not empty". The transmit-free condition is "transmit FIFO not full". The transmitter-idle condition is "transmit FIFO empty and `ser_busy` low".
- R12: `irq` is high exactly when any pending bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (pops the receive FIFO at address 0) |
| addr | input | 2 | Register select |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data for the selected register (combinational) |
| uart_mode | input | 1 | High when the controller runs as a UART |
| tx_valid | output | 1 | Transmit byte available to the serializer |
| tx_data | output | 8 | Transmit byte at the FIFO head |
| tx_ready | input | 1 | Serializer takes the head byte |
| ser_busy | input | 1 | Serializer is shifting a byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error flag of the received byte |
| rx_frm_err | input | 1 | Framing error flag of the received byte |
| irq_pend | output | 3 | Pending interrupt bits |
| irq | output | 1 | OR of the pending bits |

## Verification
A data read that removes the last stored byte can coincide with the arrival of a new byte. The status update must then take the arriving byte's flags rather than clearing them, and the FIFO must still hold the new byte. The bench provokes this by storing one byte with a framing error, then asserting `rd_en` at address 0 and `rx_valid` with a parity-error byte in the same cycle. It judges the case by the read value, the status word after the edge, and the byte returned by the following read. The bench also issues reads while the FIFO is full and while it is empty, which exercises the status and overrun updates alongside the pop.

// File: rtl/sc_fe_pkg.sv
`timescale 1ns/1ps
package sc_fe_pkg;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = 32;
  localparam int NSRC   = 3;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_MODE = 2'd2;
  localparam logic [1:0] A_PEND = 2'd3;

  localparam int SRC_RXAV = 0;
  localparam int SRC_TXFR = 1;
  localparam int SRC_IDLE = 2;

  typedef struct packed {
    logic              frm_err;
    logic              par_err;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/sc_fifo.sv
`timescale 1ns/1ps
module sc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [WIDTH-1:0] after_head,
  output logic [CW-1:0]    cnt,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (do_push) wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign head       = mem[rd_q];
  assign after_head = mem[(rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1];
  assign cnt        = cnt_q;
endmodule

// File: rtl/sc_irq_src.sv
`timescale 1ns/1ps
module sc_irq_src (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic level_mode,
  input  logic clr,
  output logic pend
);
  logic prev_q, sticky_q, sticky_n;

  always_comb begin
    sticky_n = sticky_q;
    if (clr)            sticky_n = 1'b0;
    if (cond && !prev_q) sticky_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      prev_q   <= cond;
      sticky_q <= sticky_n;
    end
  end

  assign pend = level_mode ? cond : sticky_q;
endmodule

// File: rtl/sc_frontend.sv
`timescale 1ns/1ps
module sc_frontend
  import sc_fe_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int RXW = BYTE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              uart_mode,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              ser_busy,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  output logic [NSRC-1:0]   irq_pend,
  output logic              irq
);
  logic wr_data, rd_data, wr_mode, wr_pend;
  assign wr_data = wr_en && (addr == A_DATA);
  assign rd_data = rd_en && (addr == A_DATA);
  assign wr_mode = wr_en && (addr == A_MODE);
  assign wr_pend = wr_en && (addr == A_PEND);

  // transmit path
  logic [BYTE_W-1:0] tx_head, tx_after;
  logic [CW-1:0]     tx_cnt;
  logic              tx_full, tx_empty, tx_push, tx_pop;

  assign tx_push = wr_data && !tx_full;
  assign tx_pop  = tx_valid && tx_ready;

  sc_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
    .din(wdata[BYTE_W-1:0]), .head(tx_head), .after_head(tx_after),
    .cnt(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  assign tx_valid = !tx_empty;
  assign tx_data  = tx_head;

  // receive path
  rx_entry_t rx_in, rx_head, rx_after;
  logic [CW-1:0] rx_cnt;
  logic          rx_full, rx_empty, rx_push, rx_pop, ovr_event;

  assign rx_in   = '{frm_err: rx_frm_err, par_err: rx_par_err, data: rx_data};
  assign rx_pop  = rd_data && !rx_empty;
  assign rx_push = rx_valid && (!rx_full || rx_pop);
  assign ovr_event = rx_valid && rx_full && !rx_pop;

  sc_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
    .din(rx_in), .head(rx_head), .after_head(rx_after),
    .cnt(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  // status: per-byte errors and overrun
  logic par_q, par_n, frm_q, frm_n, ovr_q, ovr_n;

  always_comb begin
    par_n = par_q;
    frm_n = frm_q;
    if (uart_mode) begin
      if (rx_pop) begin
        if (rx_cnt > CW'(1)) begin
          par_n = rx_after.par_err;
          frm_n = rx_after.frm_err;
        end else if (rx_valid) begin
          par_n = rx_par_err;
          frm_n = rx_frm_err;
        end else begin
          par_n = 1'b0;
          frm_n = 1'b0;
        end
      end else if (rx_empty && rx_push) begin
        par_n = rx_par_err;
        frm_n = rx_frm_err;
      end
    end
  end

  always_comb begin
    ovr_n = ovr_q;
    if (rx_pop)    ovr_n = 1'b0;
    if (ovr_event) ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      frm_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      par_q <= par_n;
      frm_q <= frm_n;
      ovr_q <= ovr_n;
    end
  end

  // interrupt mode and sources
  logic [NSRC-1:0] mode_q, mode_n, cond;

  always_comb begin
    mode_n = mode_q;
    if (wr_mode) mode_n = wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_n;
  end

  assign cond[SRC_RXAV] = !rx_empty;
  assign cond[SRC_TXFR] = !tx_full;
  assign cond[SRC_IDLE] = tx_empty && !ser_busy;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    sc_irq_src u_src (
      .clk(clk), .rst_n(rst_n), .cond(cond[i]), .level_mode(mode_q[i]),
      .clr(wr_pend && wdata[i]), .pend(irq_pend[i])
    );
  end

  assign irq = |irq_pend;

  // read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_DATA: if (!rx_empty) rdata[BYTE_W-1:0] = rx_head.data;
      A_STAT: rdata[2:0] = {ovr_q, frm_q, par_q};
      A_MODE: rdata[NSRC-1:0] = mode_q;
      default: rdata[NSRC-1:0] = irq_pend;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{wdata[BUS_W-1:BYTE_W], tx_after, tx_cnt};
endmodule

// File: rtl/sc_frontend_chk.sv
`timescale 1ns/1ps
module sc_frontend_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [1:0]    addr,
  input logic [31:0]   wdata,
  input logic          rx_valid,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [2:0]    irq_pend,
  input logic [2:0]    mode_q,
  input logic          ovr_q,
  input logic          tx_full,
  input logic          rx_full,
  input logic          rx_empty,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  logic wr_d, rd_d;
  assign wr_d = wr_en && (addr == 2'd0);
  assign rd_d = rd_en && (addr == 2'd0);

  // R2: a full transmit queue does not grow
  p_tx_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && wr_d && !(tx_valid && tx_ready) |=> tx_cnt == $past(tx_cnt));

  // R3: a read of an empty queue leaves it empty
  p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && rd_d && !rx_valid |=> rx_empty);

  // R4: a dropped byte raises the overrun flag
  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_full && !rd_d |=> ovr_q);

  // R5: a popping read clears the overrun flag
  p_ovr_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_d && !rx_empty && !(rx_valid && rx_full && !rd_d) |=> !ovr_q);

  // R9: an edge-mode pending bit stays until cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[0] && irq_pend[0] && !(wr_en && addr == 2'd3 && wdata[0]) && !(wr_en && addr == 2'd2)
    |=> irq_pend[0]);

  // R10: a level-mode receive source follows the queue state
  p_level_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0] |-> irq_pend[0] == !rx_empty);

  // R1: occupancy stays within the configured depth
  p_depth_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));
endmodule

bind sc_frontend sc_frontend_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .irq_pend(irq_pend), .mode_q(mode_q), .ovr_q(ovr_q), .tx_full(tx_full),
  .rx_full(rx_full), .rx_empty(rx_empty), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sc_frontend_test.sv
`timescale 1ns/1ps
module sc_frontend_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        uart_mode = 1'b1;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0, ser_busy = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_par_err = 1'b0, rx_frm_err = 1'b0;
  logic [2:0]  irq_pend;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx_q[$];
  logic [9:0] rx_q[$];
  logic [31:0] v;

  always #10 clk = ~clk;

  sc_frontend uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .uart_mode(uart_mode), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .ser_busy(ser_busy),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .irq_pend(irq_pend), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    if (a == 2'd0 && !tx_ready && tx_q.size() < 4) tx_q.push_back(d[7:0]);
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] val);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 val = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic rd_data_chk(input string req);
    logic [31:0] got, exp;
    exp = (rx_q.size() > 0) ? {24'd0, rx_q.pop_front()} : 32'd0;
    exp[31:8] = '0;
    bus_rd(2'd0, got);
    check(got == exp, req, got, exp);
  endtask

  task automatic rx_send(input logic [7:0] d, input logic p, input logic f);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_par_err = p; rx_frm_err = f;
    if (rx_q.size() < 4) rx_q.push_back({f, p, d});
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic stat_chk(input logic [2:0] exp, input string req);
    logic [31:0] got;
    bus_rd(2'd1, got);
    check(got == {29'd0, exp}, req, got, {29'd0, exp});
  endtask

  task automatic pend_chk(input logic [2:0] exp, input string req);
    logic [31:0] got;
    bus_rd(2'd3, got);
    check(got == {29'd0, exp}, req, got, {29'd0, exp});
  endtask

  // scoreboard monitor for the transmit stream (R1)
  always @(negedge clk) begin
    #2;
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_q.size() == 0) check(1'b0, "R1 unexpected tx byte", {24'd0, tx_data}, 32'd0);
      else begin
        logic [7:0] e;
        e = tx_q.pop_front();
        check(tx_data == e, "R1 tx byte order", {24'd0, tx_data}, {24'd0, e});
      end
    end
  end

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    // reset state (R8)
    #15;
    addr = 2'd2; #1 check(rdata == 0, "R8 mode reset", rdata, 0);
    addr = 2'd1; #1 check(rdata == 0, "R8 status reset", rdata, 0);
    addr = 2'd3; #1 check(rdata == 0, "R8 pending reset", rdata, 0);
    check({tx_valid, irq} == 2'b00, "R8 outputs reset", {30'd0, tx_valid, irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    pend_chk(3'b110, "R9 reset rise of tx conditions");
    bus_wr(2'd3, 32'h7);
    pend_chk(3'b000, "R9 write-one clear");

    // transmit fill, overflow write, level-mode tx_free (R1 R2 R11)
    for (int i = 0; i < 5; i++) bus_wr(2'd0, 32'hFFFF_FFA1 + i);
    bus_wr(2'd2, 32'h2);
    pend_chk(3'b000, "R11 tx_free low when full");
    bus_wr(2'd2, 32'h0);
    @(negedge clk); ser_busy = 1'b1; tx_ready = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk); tx_ready = 1'b0;
    #3 check(tx_q.size() == 0 && !tx_valid, "R2 fifth byte dropped", {31'd0, tx_valid}, 0);
    bus_rd(2'd3, v);
    check(v[1] == 1'b1, "R9 tx_free edge pending", v, 32'h2);

    // transmitter idle in level mode (R10 R11)
    bus_wr(2'd2, 32'h4);
    bus_rd(2'd3, v);
    check(v[2] == 1'b0, "R11 idle low while busy", v, 0);
    @(negedge clk); ser_busy = 1'b0;
    bus_rd(2'd3, v);
    check(v[2] == 1'b1, "R10 idle follows condition", v, 32'h4);
    bus_wr(2'd2, 32'h0);

    // receive with errors and overrun, UART mode (R3 R4 R5 R6)
    rx_send(8'h11, 1'b1, 1'b0);
    stat_chk(3'b001, "R6 arrival into empty loads flags");
    rx_send(8'h22, 1'b0, 1'b1);
    rx_send(8'h33, 1'b0, 1'b0);
    rx_send(8'h44, 1'b1, 1'b1);
    rx_send(8'h55, 1'b0, 1'b0);
    stat_chk(3'b101, "R4 overrun on full");
    rd_data_chk("R3 oldest byte");
    stat_chk(3'b010, "R5 R6 overrun cleared, next flags");
    rd_data_chk("R3 second byte");
    stat_chk(3'b000, "R6 next flags clear");
    rd_data_chk("R3 third byte");
    stat_chk(3'b011, "R6 next flags both");
    rd_data_chk("R4 dropped byte absent");
    stat_chk(3'b000, "R6 cleared when empty");
    rd_data_chk("R3 empty read zero");
    stat_chk(3'b000, "R3 empty read no change");

    // read of last byte coinciding with an arrival (R6)
    rx_send(8'h66, 1'b0, 1'b1);
    stat_chk(3'b010, "R6 frm flag of head");
    @(negedge clk);
    addr = 2'd0; rd_en = 1'b1;
    rx_valid = 1'b1; rx_data = 8'h77; rx_par_err = 1'b1; rx_frm_err = 1'b0;
    #1 check(rdata == 32'h66, "R3 read during arrival", rdata, 32'h66);
    void'(rx_q.pop_front());
    rx_q.push_back({1'b0, 1'b1, 8'h77});
    @(posedge clk); #1 rd_en = 1'b0; rx_valid = 1'b0;
    stat_chk(3'b001, "R6 arriving byte becomes head");
    rd_data_chk("R3 arriving byte kept");

    // non-UART mode holds error bits (R7)
    rx_send(8'h99, 1'b1, 1'b0);
    @(negedge clk); uart_mode = 1'b0;
    rd_data_chk("R3 byte in non-uart mode");
    stat_chk(3'b001, "R7 error bits held");
    @(negedge clk); uart_mode = 1'b1;

    // receive interrupt modes and irq output (R9 R10 R12)
    bus_wr(2'd3, 32'h7);
    pend_chk(3'b000, "R9 all cleared");
    #1 check(irq == 1'b0, "R12 irq low", {31'd0, irq}, 0);
    bus_wr(2'd2, 32'h1);
    rx_send(8'hAB, 1'b0, 1'b0);
    pend_chk(3'b001, "R10 rx level follows");
    #1 check(irq == 1'b1, "R12 irq high", {31'd0, irq}, 1);
    bus_wr(2'd2, 32'h0);
    pend_chk(3'b001, "R9 rx edge sticky");
    bus_wr(2'd3, 32'h1);
    pend_chk(3'b000, "R9 no re-raise without edge");
    rd_data_chk("R3 drain");

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule